// File: doc/BRIEF.md
# Minimal UART Transceiver Core

This core moves characters between a parallel host side and a pair of asynchronous serial lines. On the transmit side the host pushes characters into a small queue. The core wraps each character in a start bit and a stop bit and shifts it out least significant bit first. On the receive side the core watches the incoming line, qualifies a start bit, samples the data bits near their centres and queues the finished characters for the host to pop. Either 7 or 8 data bits can be selected. The frame has no parity bit.

Bit timing comes from a 16-bit divisor. A baud tick fires once every `divisor` system clocks, and each serial bit lasts eight ticks, so the bit rate is the clock divided by eight times the divisor. The receiver does not check the stop bit, does not report breaks and has no idle timeout. The only error it reports is an overrun. The host can hold the transmit line low to send a break. Separate enables gate each direction. With both enables low, the word length and the divisor can be changed without corrupting a frame. Register decoding for the bus is done in a neighbouring block that drives these ports.

Top module: `lite_uart_core`

## Requirements
- R1: The idle transmit line is 1. A frame is a 0 start bit, then the data bits least significant first, then a single 1 stop bit, with no parity. `wordLen8`=1 selects 8 data bits. `wordLen8`=0 selects 7 data bits, and bit 7 of the character is not sent.
- R2: A baud tick fires every `divisor` clocks, and a value of 0 acts as 1. Every bit after the start bit lasts exactly 8 ticks, which is 8*divisor clocks. The start bit ends on the 8th tick after the character is loaded.
- R3: The transmit queue holds 8 characters. `txCanAccept` is 1 while fewer than 8 are held. A push made while 8 are held is discarded.
- R4: A new frame starts only while `txEn` is 1, and a frame already in progress always completes. `txIdle` is 1 exactly when the transmit queue is empty and no frame is being shifted.
- R5: While `breakReq` is 1, `txLine` is 0 in that same cycle. Break does not change the queue or the frame timing.
- R6: `rxLine` passes through a two-flop synchroniser. A low level seen while the receiver is idle starts a frame. At the 4th tick the start bit must still be low, or the frame is dropped as a glitch. Each data bit is sampled at the 4th tick of its period. The stop bit is not checked, and the character is delivered at the middle of the stop bit. A 7-bit character is zero-extended, so bit 7 reads 0.
- R7: The receive queue holds 8 characters. `rxAvail` is 1 while it is not empty, and `rxData` shows the oldest character. A `rxPop` pulse removes that character.
- R8: A character that completes while the receive queue holds 8 characters is discarded and sets `overrun`. `overrun` stays set until a `statusRead` pulse clears it. If a new overrun and a clear fall in the same cycle, the set wins.
- R9: While `rxEn` is 0 the receiver stays idle and ignores `rxLine`.
- R10: After reset, `txLine`=1, `txCanAccept`=1, `txIdle`=1, `rxAvail`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEn | input | 1 | Receiver enable |
| txEn | input | 1 | Transmitter enable (gates the start of new frames) |
| wordLen8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| breakReq | input | 1 | Force the transmit line low |
| divisor | input | 16 | Clocks per baud tick (0 treated as 1) |
| txData | input | 8 | Character to queue for transmission |
| txPush | input | 1 | Push `txData` into the transmit queue |
| rxPop | input | 1 | Remove the oldest received character |
| statusRead | input | 1 | Clears the sticky overrun flag |
| rxLine | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit line |
| rxData | output | 8 | Oldest received character |
| rxAvail | output | 1 | Receive queue not empty |
| overrun | output | 1 | Sticky overrun flag |
| txCanAccept | output | 1 | Transmit queue has room |
| txIdle | output | 1 | Transmit queue empty and shifter finished |

## Verification
Several outputs follow a push, pop or status pulse on the next clock edge: the queue flags, `rxData`, `rxAvail` and the cleared `overrun`. `txLine` follows `breakReq` in the same cycle. A character on `rxLine` reaches `rxData` two synchroniser cycles plus the mid-stop sample point after its start edge. The bench's reference model keeps queues and tick counters of its own. It updates on every rising edge from the inputs held across that edge. Inputs change one nanosecond after the edge, and all outputs are compared at the falling edge, so each result is checked in the cycle it is due.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
  localparam int DATA_W    = 8;
  localparam int OVS       = 8;               // ticks per serial bit
  localparam int SUB_W     = $clog2(OVS);
  localparam int MID_TICK  = OVS / 2 - 1;     // 4th tick of a bit
  localparam int IDX_W     = $clog2(DATA_W + 2);

  typedef struct packed {
    logic txLoad;     // move queue head into the shifter
    logic txAdvance;  // shift out the next bit
    logic rxSample;   // capture one data bit
    logic rxDeliver;  // character complete at mid stop bit
  } uart_strobe_t;
endpackage

// File: rtl/lite_uart_fifo.sv
module lite_uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> (count == $past(count) + 1'b1)); // R3

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push) |=> (count == $past(count) - 1'b1)); // R7
endmodule

// File: rtl/lite_uart_ctrl.sv
module lite_uart_ctrl
  import lite_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEn,
  input  logic             txEn,
  input  logic             wordLen8,
  input  logic [DIV_W-1:0] divisor,
  input  logic             txEmpty,
  input  logic             rxBit,
  output uart_strobe_t     st,
  output logic             txBusy
);
  logic [DIV_W-1:0] divCnt, reloadVal;
  logic             tick;
  logic [SUB_W-1:0] txSub, rxSub;
  logic [IDX_W-1:0] txIdx, rxIdx, stopIdx;
  logic             rxBusy, midTick;

  assign reloadVal = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick      = (divCnt == '0);
  assign stopIdx   = wordLen8 ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W);
  assign midTick   = rxBusy && tick && (rxSub == SUB_W'(MID_TICK));

  always_comb begin
    st.txLoad    = !txBusy && txEn && !txEmpty;
    st.txAdvance = txBusy && tick && (txSub == SUB_W'(OVS - 1));
    st.rxSample  = midTick && (rxIdx != '0) && (rxIdx != stopIdx);
    st.rxDeliver = midTick && (rxIdx == stopIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      txBusy <= 1'b0;
      txSub  <= '0;
      txIdx  <= '0;
      rxBusy <= 1'b0;
      rxSub  <= '0;
      rxIdx  <= '0;
    end else begin
      divCnt <= tick ? reloadVal : divCnt - 1'b1;

      if (st.txLoad) begin
        txBusy <= 1'b1;
        txSub  <= '0;
        txIdx  <= '0;
      end else if (txBusy && tick) begin
        txSub <= txSub + 1'b1;
        if (txSub == SUB_W'(OVS - 1)) begin
          txIdx <= txIdx + 1'b1;
          if (txIdx == stopIdx) txBusy <= 1'b0;
        end
      end

      if (!rxEn) begin
        rxBusy <= 1'b0;
      end else if (!rxBusy) begin
        if (!rxBit) begin
          rxBusy <= 1'b1;
          rxSub  <= '0;
          rxIdx  <= '0;
        end
      end else if (tick) begin
        rxSub <= rxSub + 1'b1;
        if (rxSub == SUB_W'(OVS - 1)) rxIdx <= rxIdx + 1'b1;
        if (midTick && (((rxIdx == '0) && rxBit) || (rxIdx == stopIdx)))
          rxBusy <= 1'b0;
      end
    end
  end

  AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(txEn)); // R4

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (midTick && (rxIdx == '0) && rxBit) |=> !rxBusy); // R6

  AST_RX_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !rxBusy); // R9
endmodule

// File: rtl/lite_uart_datapath.sv
module lite_uart_datapath
  import lite_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  uart_strobe_t      st,
  input  logic              txBusy,
  input  logic              wordLen8,
  input  logic              breakReq,
  input  logic [DATA_W-1:0] txData,
  input  logic              txPush,
  input  logic              rxPop,
  input  logic              statusRead,
  input  logic              rxLine,
  output logic              rxBit,
  output logic              txEmpty,
  output logic              txLine,
  output logic              txCanAccept,
  output logic              txIdle,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAvail,
  output logic              overrun
);
  localparam int FRAME_W = DATA_W + 2;

  logic [DATA_W-1:0]  txHead, rxShift, rxChar;
  logic [FRAME_W-1:0] txShift;
  logic               txFull, rxEmpty, rxFull;
  logic               syncA, syncB;

  lite_uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk, .rstN,
    .push(txPush && !txFull), .pop(st.txLoad),
    .wrData(txData), .rdData(txHead), .empty(txEmpty), .full(txFull));

  lite_uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk, .rstN,
    .push(st.rxDeliver && !rxFull), .pop(rxPop && !rxEmpty),
    .wrData(rxChar), .rdData(rxData), .empty(rxEmpty), .full(rxFull));

  assign rxChar = wordLen8 ? rxShift : {1'b0, rxShift[DATA_W-1:1]};
  assign rxBit  = syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      txShift <= '1;
      rxShift <= '0;
      overrun <= 1'b0;
    end else begin
      syncA <= rxLine;
      syncB <= syncA;
      if (st.txLoad)
        txShift <= wordLen8 ? {1'b1, txHead, 1'b0}
                            : {2'b11, txHead[DATA_W-2:0], 1'b0};
      else if (st.txAdvance)
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
      if (st.rxSample) rxShift <= {syncB, rxShift[DATA_W-1:1]};
      if (st.rxDeliver && rxFull) overrun <= 1'b1;
      else if (statusRead)        overrun <= 1'b0;
    end
  end

  assign txLine      = breakReq ? 1'b0 : (txBusy ? txShift[0] : 1'b1);
  assign txCanAccept = !txFull;
  assign txIdle      = txEmpty && !txBusy;
  assign rxAvail     = !rxEmpty;

  AST_TX_HOLD_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !st.txAdvance && !st.txLoad) |=> (txShift == $past(txShift))); // R2

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !statusRead) |=> overrun); // R8

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxDeliver && rxFull && !rxPop) |=> (rxFull && overrun)); // R8
endmodule

// File: rtl/lite_uart_core.sv
module lite_uart_core
  import lite_uart_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              txEn,
  input  logic              wordLen8,
  input  logic              breakReq,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [DATA_W-1:0] txData,
  input  logic              txPush,
  input  logic              rxPop,
  input  logic              statusRead,
  input  logic              rxLine,
  output logic              txLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAvail,
  output logic              overrun,
  output logic              txCanAccept,
  output logic              txIdle
);
  uart_strobe_t st;
  logic         txBusy, txEmpty, rxBit;

  lite_uart_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk, .rstN, .rxEn, .txEn, .wordLen8, .divisor,
    .txEmpty, .rxBit, .st, .txBusy);

  lite_uart_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) i_dp (
    .clk, .rstN, .st, .txBusy, .wordLen8, .breakReq, .txData, .txPush,
    .rxPop, .statusRead, .rxLine, .rxBit, .txEmpty, .txLine, .txCanAccept,
    .txIdle, .rxData, .rxAvail, .overrun);
endmodule

// File: tb/test_lite_uart_core.sv
`timescale 1ns/100ps
module test_lite_uart_core;
  logic        clk = 0, rstN = 0;
  logic        rxEn = 0, txEn = 0, wordLen8 = 1, breakReq = 0;
  logic [15:0] divisor = 16'd2;
  logic [7:0]  txData = 0;
  logic        txPush = 0, rxPop = 0, statusRead = 0, rxLine = 1;
  logic        txLine, rxAvail, overrun, txCanAccept, txIdle;
  logic [7:0]  rxData;

  lite_uart_core i_lite_uart_core (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit running = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  int         mCnt = 0, mTxTicks = 0, mTxPos = 0, mRxTicks = 0, mRxPos = 0;
  bit         mTxBusy = 0, mRxBusy = 0, mOvr = 0, mS1 = 1, mS2 = 1;
  logic [9:0] mTxFrame = '1;
  logic [7:0] mRxAcc = 0, mChar;
  logic [7:0] mTxQ[$], mRxQ[$];
  bit         tk, sNow, del;
  int         preN, preR, nb;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mCnt = 0; mTxBusy = 0; mRxBusy = 0; mOvr = 0; mS1 = 1; mS2 = 1;
      mTxQ.delete(); mRxQ.delete();
    end else begin
      nb = wordLen8 ? 8 : 7;
      tk = (mCnt == 0);
      mCnt = tk ? ((divisor == 0) ? 0 : int'(divisor) - 1) : mCnt - 1;
      preN = mTxQ.size();
      if (!mTxBusy && txEn && preN > 0) begin
        mChar = mTxQ.pop_front();
        mTxFrame = '1;
        mTxFrame[0] = 1'b0;
        for (int i = 0; i < nb; i++) mTxFrame[i+1] = mChar[i];
        mTxBusy = 1; mTxTicks = 0; mTxPos = 0;
      end else if (mTxBusy && tk) begin
        mTxTicks++;
        if (mTxTicks == 8) begin
          mTxTicks = 0; mTxPos++;
          if (mTxPos > nb + 1) mTxBusy = 0;
        end
      end
      if (txPush && preN < 8) mTxQ.push_back(txData);

      sNow = mS2; mS2 = mS1; mS1 = rxLine;
      preR = mRxQ.size(); del = 0;
      if (!rxEn) mRxBusy = 0;
      else if (!mRxBusy) begin
        if (!sNow) begin mRxBusy = 1; mRxTicks = 0; mRxPos = 0; end
      end else if (tk) begin
        if (mRxTicks == 3) begin
          if (mRxPos == 0) begin if (sNow) mRxBusy = 0; end
          else if (mRxPos <= nb) mRxAcc[mRxPos-1] = sNow;
          else begin del = 1; mRxBusy = 0; end
        end
        mRxTicks = (mRxTicks + 1) % 8;
        if (mRxTicks == 0) mRxPos++;
      end
      if (rxPop && preR > 0) void'(mRxQ.pop_front());
      if (statusRead) mOvr = 0;
      if (del) begin
        if (preR == 8) mOvr = 1;
        else mRxQ.push_back(wordLen8 ? mRxAcc : {1'b0, mRxAcc[6:0]});
      end
    end
  end

  logic expLine;
  always @(negedge clk) if (rstN && running && !finished) begin
    expLine = breakReq ? 1'b0 : (mTxBusy ? mTxFrame[mTxPos] : 1'b1);
    chk(txLine === expLine, "R1/R2/R5 txLine", txLine, expLine);
    chk(txCanAccept === (mTxQ.size() < 8), "R3 txCanAccept", txCanAccept, mTxQ.size() < 8);
    chk(txIdle === (mTxQ.size() == 0 && !mTxBusy), "R4 txIdle", txIdle,
        mTxQ.size() == 0 && !mTxBusy);
    chk(rxAvail === (mRxQ.size() > 0), "R7 rxAvail", rxAvail, mRxQ.size() > 0);
    if (mRxQ.size() > 0) chk(rxData === mRxQ[0], "R6 rxData", rxData, mRxQ[0]);
    chk(overrun === mOvr, "R8 overrun", overrun, mOvr);
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(posedge clk); #1; endtask

  task automatic push(input logic [7:0] d);
    txPush = 1; txData = d; step(); txPush = 0;
  endtask

  task automatic waitTx();
    while (mTxQ.size() > 0 || mTxBusy) step();
    step();
  endtask

  task automatic hold(input logic v, input int n);
    rxLine = v;
    repeat (n) step();
  endtask

  task automatic rxFrame(input logic [7:0] d, input int bits);
    int bt = 8 * int'(divisor);
    hold(1'b0, bt);
    for (int i = 0; i < bits; i++) hold(d[i], bt);
    hold(1'b1, bt);
    hold(1'b1, bt / 2);
  endtask

  task automatic popOne(input logic [7:0] exp, input string req);
    chk(rxData === exp, req, rxData, exp);
    rxPop = 1; step(); rxPop = 0;
  endtask

  always @(posedge clk) if (cyc > 100000 && !finished) begin
    finished = 1;
    chk(0, "watchdog", cyc, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int n;
  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1; running = 1;
    chk(txLine === 1'b1 && txCanAccept === 1'b1 && txIdle === 1'b1 &&
        rxAvail === 1'b0 && overrun === 1'b0, "R10 reset state",
        {txLine, txCanAccept, txIdle, rxAvail, overrun}, 5'b11100);

    // 8-bit transmit
    txEn = 1; rxEn = 1; wordLen8 = 1;
    push(8'hA5); push(8'h00); push(8'hFF);
    waitTx();
    // 7-bit transmit: bit 7 not sent
    wordLen8 = 0;
    push(8'hFF); push(8'h3A);
    waitTx();
    wordLen8 = 1;

    // queue fill with transmitter gated
    txEn = 0;
    for (int i = 0; i < 10; i++) push(8'(i * 17 + 3));
    step();
    chk(txCanAccept === 1'b0, "R3 full after 10 pushes", txCanAccept, 0);
    repeat (40) step();
    chk(txIdle === 1'b0 && txLine === 1'b1, "R4 gated by txEn", {txIdle, txLine}, 2'b01);
    txEn = 1;
    waitTx();

    // break
    breakReq = 1; step();
    chk(txLine === 1'b0, "R5 break low", txLine, 0);
    push(8'h81);
    repeat (30) step();
    breakReq = 0;
    waitTx();

    // receive 8-bit
    rxFrame(8'hA5, 8); rxFrame(8'h3C, 8);
    popOne(8'hA5, "R6 rx 8-bit first"); popOne(8'h3C, "R7 rx order");
    // glitch
    hold(1'b0, 4); hold(1'b1, 60);
    chk(rxAvail === 1'b0, "R6 glitch rejected", rxAvail, 0);
    // stop bit not checked
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(1'b1, 16);
    hold(1'b0, 16); hold(1'b1, 40);
    chk(rxAvail === 1'b1 && rxData === 8'hFF, "R6 bad stop accepted", rxData, 8'hFF);
    rxPop = 1; step(); rxPop = 0; step();
    // 7-bit receive
    wordLen8 = 0;
    rxFrame(8'h55, 7);
    popOne(8'h55, "R6 rx 7-bit zero-extend");
    wordLen8 = 1;

    // overrun
    for (int i = 0; i < 9; i++) rxFrame(8'(8'h10 + i), 8);
    chk(overrun === 1'b1, "R8 overrun set", overrun, 1);
    repeat (5) step();
    chk(overrun === 1'b1, "R8 overrun sticky", overrun, 1);
    statusRead = 1; step(); statusRead = 0; step();
    chk(overrun === 1'b0, "R8 overrun cleared", overrun, 0);
    for (int i = 0; i < 8; i++) popOne(8'(8'h10 + i), "R7 rx queue drain");
    step();
    chk(rxAvail === 1'b0, "R7 empty after drain", rxAvail, 0);

    // receiver disabled
    rxEn = 0;
    rxFrame(8'h42, 8);
    chk(rxAvail === 1'b0, "R9 rx disabled ignores line", rxAvail, 0);
    rxEn = 1;

    // bit period measurement
    divisor = 16'd3; step();
    push(8'h55);
    @(negedge clk); while (txLine !== 1'b0) @(negedge clk);
    while (txLine !== 1'b1) @(negedge clk);
    n = 0;
    while (txLine !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
    chk(n == 24, "R2 bit length 8*divisor", n, 24);
    step();
    waitTx();

    // divisor zero acts as one
    divisor = 16'd0; step();
    push(8'hC3);
    waitTx();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule